// File: doc/BRIEF.md
# Memory Card Host Write-Data Sequencer

This block runs the host-to-card data phase of a single-bit memory card write. Software sets a transfer enable and then loads a transmit FIFO. Once the FIFO is at least half full, the command response has arrived with a good status, a programmable gap has elapsed and the card is not signalling busy, the block serializes FIFO words onto the data line. One bit goes out per clock. The clock is the card clock.

In the block modes, each block is framed with a start bit, a CRC16 and an end bit. The block then releases the line and captures the card's three-bit CRC status token. It waits out the card's busy period and then raises end-of-block and, where the mode calls for it, end-of-frame. Stream mode sends words back to back with no CRC until a stop command has been issued. Flags drive a masked interrupt output.

Top module: `sdwr_seq`

## Requirements
- R1: After reset, dat_oe=0, dat_out=1, xfer_en=0, busy=0, irq=0, and eob_flag, eof_flag, tok_fmt_ok and crc_err are all 0. A pulse on arm sets xfer_en.
- R2: The first block of a transfer starts only when all of these hold: xfer_en=1, fifo_level ≥ FIFO_DEPTH/2, rsp_seen=1, rsp_ok=1, and dat_in=1 (card not busy). With a bad response, a FIFO below half or a low dat_in, dat_oe stays 0.
- R3: Let G = 3 + 2·gap_code, which gives 3, 5, 7 or 9. With the other conditions already met, dat_oe first rises on the (G+1)th rising edge after rsp_seen is raised. If rsp_seen has been high for at least G cycles, the start follows on the next edge after the last condition becomes true.
- R4: In the block modes, a block on dat_out is sent as follows, one bit per clock while dat_oe=1:
  - a start bit of 0;
  - BLK_WORDS FIFO words, each MSB first and each taken with a one-cycle fifo_pop;
  - the CRC16 of the payload (x^16+x^12+x^5+1, initial value 0), MSB first;
  - an end bit of 1.
- R5: After the end bit the line is released. The card token is a 0 start bit, three status bits and an end bit. tok_fmt_ok takes the end bit's value. Any status other than 010 sets crc_err.
- R6: crc_err is sticky. Only crc_clr clears it, and flag_ack has no effect on it.
- R7: busy is 1 while the block waits after the token and dat_in is 0.
- R8: In single-block mode (mode=1), when busy ends, eob_flag and eof_flag rise in the same cycle and xfer_en falls.
- R9: In multi-block mode (mode=2), eob_flag is set when busy ends after every block. The next block starts once the FIFO is half full again. eof_flag is set, and xfer_en cleared, only when busy ends after stop_sent has been pulsed.
- R10: In stream mode (mode=0), words go out back to back with no CRC and no token. After a stop_sent pulse, the current word finishes and an end bit of 1 follows, with no further fifo_pop. eof_flag is then set and xfer_en cleared.
- R11: irq = OR of (flags & irq_mask), with bit0=eob_flag, bit1=eof_flag and bit2=crc_err. flag_ack bit0 clears eob_flag and bit1 clears eof_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Pulse that sets the transfer enable |
| mode | input | 2 | 0 stream, 1 single block, 2 multi block |
| gap_code | input | CODE_W | Response-to-data gap code |
| fifo_level | input | LVL_W | Words held in the transmit FIFO |
| fifo_data | input | DW | Head word of the FIFO (show-ahead) |
| fifo_pop | output | 1 | Takes the head word this cycle |
| rsp_seen | input | 1 | Write-command response received (level) |
| rsp_ok | input | 1 | Response status good |
| stop_sent | input | 1 | Pulse: stop command issued |
| dat_in | input | 1 | Sampled data line from the card |
| dat_out | output | 1 | Data line drive value |
| dat_oe | output | 1 | Data line drive enable |
| xfer_en | output | 1 | Transfer enable state |
| busy | output | 1 | Card busy after a block |
| eob_flag | output | 1 | End-of-block flag |
| eof_flag | output | 1 | End-of-frame flag |
| tok_fmt_ok | output | 1 | Last token end bit valid |
| crc_err | output | 1 | Sticky: card rejected a block CRC |
| flag_ack | input | 2 | Clears eob_flag (bit0) and eof_flag (bit1) |
| crc_clr | input | 1 | Clears crc_err |
| irq_mask | input | 3 | Per-flag interrupt enables |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench measures the exact start edge for gap codes 0, 1 and 3. A design that counts the gap from the wrong edge would start one cycle early or late. The bench holds back each start condition in turn: a FIFO below half, a bad response, and a card holding the line low. A design that ignores any of them drives data too soon. A bit-level scoreboard compares every driven bit against frames built in the bench with an independently computed CRC16, which catches bit-order, CRC or framing slips. Bad tokens, stop timing in stream and multi-block modes, and acknowledge against the sticky CRC flag are each checked at the flag and enable outputs.

// File: rtl/sdwr_pkg.sv
package sdwr_pkg;
   typedef enum logic [1:0] {
      MD_STREAM = 2'd0,
      MD_SINGLE = 2'd1,
      MD_MULTI  = 2'd2
   } mode_e;

   typedef enum logic [3:0] {
      S_IDLE, S_START, S_DATA, S_CRC, S_ENDB,
      S_TOKWAIT, S_TOK, S_BUSY, S_NEXT
   } st_e;

   localparam int CRC_W    = 16;
   localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
   localparam int NFLAG    = 3;
   localparam int FL_EOB   = 0;
   localparam int FL_EOF   = 1;
   localparam int FL_CRC   = 2;
   localparam logic [2:0] TOK_ACCEPT = 3'b010;
endpackage

// File: rtl/sdwr_crc16.sv
module sdwr_crc16 #(
   parameter int W = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic upd,
   input  logic bit_in,
   input  logic shift,
   output logic msb
);
   generate
      if (W < 2) begin : g_bad_w
         $error("sdwr_crc16: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] crc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc <= '0;
      else if (clr)    crc <= '0;
      else if (upd)    crc <= {crc[W-2:0], 1'b0} ^ ((crc[W-1] ^ bit_in) ? POLY : '0);
      else if (shift)  crc <= {crc[W-2:0], 1'b0};
   end

   assign msb = crc[W-1];
endmodule

// File: rtl/sdwr_gap.sv
module sdwr_gap #(
   parameter int CODE_W = 2,
   parameter int BASE   = 3,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_seen,
   input  logic [CODE_W-1:0] code,
   output logic              met
);
   localparam int MAXG  = BASE + STEP * ((1 << CODE_W) - 1);
   localparam int AGE_W = $clog2(MAXG + 1);

   generate
      if (CODE_W < 1 || BASE < 1 || STEP < 0) begin : g_bad_cfg
         $error("sdwr_gap: illegal gap configuration");
      end
   endgenerate

   logic [AGE_W-1:0] age;
   logic [AGE_W-1:0] need;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      age <= '0;
      else if (!rsp_seen)              age <= '0;
      else if (age != AGE_W'(MAXG))    age <= age + AGE_W'(1);
   end

   assign need = AGE_W'(BASE) + AGE_W'(STEP) * AGE_W'(code);
   assign met  = (age >= need);
endmodule

// File: rtl/sdwr_flags.sv
module sdwr_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] mask,
   output logic [N-1:0] flag,
   output logic         irq
);
   generate
      if (N < 1) begin : g_bad_n
         $error("sdwr_flags: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
         end
      end
   endgenerate

   assign irq = |(flag & mask);
endmodule

// File: rtl/sdwr_seq.sv
module sdwr_seq
   import sdwr_pkg::*;
#(
   parameter int DW         = 8,
   parameter int BLK_WORDS  = 4,
   parameter int FIFO_DEPTH = 8,
   parameter int CODE_W     = 2,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [1:0]        mode,
   input  logic [CODE_W-1:0] gap_code,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [DW-1:0]     fifo_data,
   output logic              fifo_pop,
   input  logic              rsp_seen,
   input  logic              rsp_ok,
   input  logic              stop_sent,
   input  logic              dat_in,
   output logic              dat_out,
   output logic              dat_oe,
   output logic              xfer_en,
   output logic              busy,
   output logic              eob_flag,
   output logic              eof_flag,
   output logic              tok_fmt_ok,
   output logic              crc_err,
   input  logic [1:0]        flag_ack,
   input  logic              crc_clr,
   input  logic [2:0]        irq_mask,
   output logic              irq
);
   localparam int HALF = FIFO_DEPTH / 2;
   localparam int BC_W = $clog2((DW > CRC_W) ? DW : CRC_W);
   localparam int WC_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

   generate
      if (DW < 2 || BLK_WORDS < 1 || FIFO_DEPTH < 2) begin : g_bad_cfg
         $error("sdwr_seq: illegal width or depth");
      end
   endgenerate

   st_e             st;
   logic [DW-1:0]   sh;
   logic [BC_W-1:0] bcnt;
   logic [WC_W-1:0] wcnt;
   logic [1:0]      tcnt;
   logic [2:0]      tok;
   logic            en, stop_lat, fmt_ok;

   logic gap_met, crc_msb, lvl_ok, is_stream, is_single;
   logic go_first, go_next, word_end, last_word, load_word;
   logic busy_end, frame_done, tok_last;
   logic [NFLAG-1:0] fl_set, fl_clr, fl;

   sdwr_gap #(.CODE_W(CODE_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .rsp_seen(rsp_seen), .code(gap_code), .met(gap_met));

   assign lvl_ok    = (fifo_level >= LVL_W'(HALF));
   assign is_stream = (mode == MD_STREAM);
   assign is_single = (mode == MD_SINGLE);
   assign go_first  = en && (st == S_IDLE) && lvl_ok && rsp_seen && rsp_ok && gap_met && dat_in;
   assign go_next   = (st == S_NEXT) && lvl_ok && dat_in && !stop_lat;
   assign word_end  = (st == S_DATA) && (bcnt == BC_W'(DW-1));
   assign last_word = (wcnt == WC_W'(BLK_WORDS-1));
   assign load_word = go_first || go_next ||
                      (word_end && (is_stream ? !stop_lat : !last_word));
   assign busy_end  = (st == S_BUSY) && dat_in;
   assign tok_last  = (st == S_TOK) && (tcnt == 2'd3);
   assign frame_done = ((st == S_ENDB) && is_stream) ||
                       (busy_end && (is_single || stop_lat)) ||
                       ((st == S_NEXT) && stop_lat);

   sdwr_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n),
      .clr(go_first || go_next),
      .upd(st == S_DATA), .bit_in(sh[DW-1]),
      .shift(st == S_CRC),
      .msb(crc_msb));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; sh <= '0; bcnt <= '0; wcnt <= '0;
         tcnt <= '0; tok <= '0; fmt_ok <= 1'b0;
      end else begin
         case (st)
            S_IDLE, S_NEXT: begin
               if (go_first || go_next) begin
                  st <= S_START; sh <= fifo_data; bcnt <= '0; wcnt <= '0;
               end else if (st == S_NEXT && stop_lat) begin
                  st <= S_IDLE;
               end
            end
            S_START: st <= S_DATA;
            S_DATA: begin
               if (word_end) begin
                  bcnt <= '0;
                  if (load_word) begin
                     sh   <= fifo_data;
                     wcnt <= wcnt + WC_W'(1);
                  end else begin
                     st <= is_stream ? S_ENDB : S_CRC;
                  end
               end else begin
                  sh   <= sh << 1;
                  bcnt <= bcnt + BC_W'(1);
               end
            end
            S_CRC: begin
               if (bcnt == BC_W'(CRC_W-1)) begin
                  bcnt <= '0; st <= S_ENDB;
               end else begin
                  bcnt <= bcnt + BC_W'(1);
               end
            end
            S_ENDB: st <= is_stream ? S_IDLE : S_TOKWAIT;
            S_TOKWAIT: if (!dat_in) begin st <= S_TOK; tcnt <= '0; end
            S_TOK: begin
               if (tok_last) begin
                  fmt_ok <= dat_in; st <= S_BUSY;
               end else begin
                  tok  <= {tok[1:0], dat_in};
                  tcnt <= tcnt + 2'd1;
               end
            end
            S_BUSY: if (dat_in) st <= (is_single || stop_lat) ? S_IDLE : S_NEXT;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0; stop_lat <= 1'b0;
      end else begin
         if (frame_done)  en <= 1'b0;
         else if (arm)    en <= 1'b1;
         if (frame_done || arm)     stop_lat <= 1'b0;
         else if (stop_sent && en)  stop_lat <= 1'b1;
      end
   end

   always_comb begin
      case (st)
         S_START: dat_out = 1'b0;
         S_DATA:  dat_out = sh[DW-1];
         S_CRC:   dat_out = crc_msb;
         default: dat_out = 1'b1;
      endcase
   end

   assign dat_oe   = (st == S_START) || (st == S_DATA) || (st == S_CRC) || (st == S_ENDB);
   assign fifo_pop = load_word;
   assign busy     = (st == S_BUSY) && !dat_in;
   assign xfer_en  = en;
   assign tok_fmt_ok = fmt_ok;

   assign fl_set[FL_EOB] = busy_end;
   assign fl_set[FL_EOF] = frame_done;
   assign fl_set[FL_CRC] = tok_last && (tok != TOK_ACCEPT);
   assign fl_clr[FL_EOB] = flag_ack[0];
   assign fl_clr[FL_EOF] = flag_ack[1];
   assign fl_clr[FL_CRC] = crc_clr;

   sdwr_flags #(.N(NFLAG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(fl_set), .clr(fl_clr),
      .mask(irq_mask), .flag(fl), .irq(irq));

   assign eob_flag = fl[FL_EOB];
   assign eof_flag = fl[FL_EOF];
   assign crc_err  = fl[FL_CRC];

   // R2: a first-block start only follows a good, aged response
   a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dat_oe) && $past(st) == S_IDLE) |-> $past(gap_met && rsp_seen && rsp_ok && dat_in));

   // R4: the line is never driven outside an enabled transfer
   a_r4_drive_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe |-> xfer_en);

   // R6: the CRC status flag holds until its own clear
   a_r6_crc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_err && !crc_clr) |=> crc_err);

   // R7: busy only while the host has released the line
   a_r7_busy_released: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!dat_oe && xfer_en && !dat_in));

   // R8: single block ends with both flags and the enable cleared together
   a_r8_single_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eof_flag) && mode == MD_SINGLE) |-> (eob_flag && !xfer_en));
endmodule

// File: tb/sdwr_seq_test.sv
`timescale 1ns/1ps
module sdwr_seq_test;
   localparam int DW = 8, BLK = 4, DEPTH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic arm = 0, stop_sent = 0, rsp_seen = 0, rsp_ok = 0, dat_in = 1, crc_clr = 0;
   logic [1:0] mode = 2'd1, gap_code = 2'd0, flag_ack = 2'd0;
   logic [2:0] irq_mask = 3'b111;
   logic [3:0] fifo_level = '0;
   logic [DW-1:0] fifo_data = '0;
   logic fifo_pop, dat_out, dat_oe, xfer_en, busy, eob_flag, eof_flag, tok_fmt_ok, crc_err, irq;

   int checks = 0, fails = 0, obs = 0;
   logic [DW-1:0] fq[$];
   logic [DW-1:0] wbuf[$];
   logic exp_q[$];

   always #2.5 clk = ~clk;

   sdwr_seq #(.DW(DW), .BLK_WORDS(BLK), .FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .gap_code(gap_code),
      .fifo_level(fifo_level), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
      .rsp_seen(rsp_seen), .rsp_ok(rsp_ok), .stop_sent(stop_sent), .dat_in(dat_in),
      .dat_out(dat_out), .dat_oe(dat_oe), .xfer_en(xfer_en), .busy(busy),
      .eob_flag(eob_flag), .eof_flag(eof_flag), .tok_fmt_ok(tok_fmt_ok), .crc_err(crc_err),
      .flag_ack(flag_ack), .crc_clr(crc_clr), .irq_mask(irq_mask), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // FIFO model: show-ahead, popped on the design's request
   always @(posedge clk) begin
      if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
      fifo_level <= 4'(fq.size());
      fifo_data  <= (fq.size() > 0) ? fq[0] : '0;
   end

   // Monitor: every driven bit is compared with the scoreboard
   always @(negedge clk) begin
      if (rst_n && dat_oe) begin
         obs++;
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R4 actual=%0d expected=none (unexpected bit)", dat_out);
         end else begin
            chk("R4 bit", int'(dat_out), int'(exp_q.pop_front()));
         end
      end
   end

   task automatic push_words(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         logic [DW-1:0] w;
         w = DW'(seed * 29 + i * 53 + 7);
         fq.push_back(w);
         wbuf.push_back(w);
      end
      fifo_level = 4'(fq.size());
      fifo_data  = fq[0];
   endtask

   // Expected frame: start, words MSB first, optional CRC16, end
   task automatic expect_frame(input int nwords, input bit with_crc);
      logic [15:0] c;
      c = '0;
      exp_q.push_back(1'b0);
      for (int i = 0; i < nwords; i++) begin
         logic [DW-1:0] w;
         w = wbuf.pop_front();
         for (int b = DW-1; b >= 0; b--) begin
            exp_q.push_back(w[b]);
            c = {c[14:0], 1'b0} ^ ((c[15] ^ w[b]) ? 16'h1021 : 16'h0000);
         end
      end
      if (with_crc)
         for (int b = 15; b >= 0; b--) exp_q.push_back(c[b]);
      exp_q.push_back(1'b1);
   endtask

   task automatic pulse_arm();
      arm = 1; @(negedge clk); arm = 0;
   endtask

   // Raise rsp_seen and count edges until the line is driven
   task automatic start_and_time(input string req, input int g);
      int k;
      rsp_ok = 1; rsp_seen = 1;
      k = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); k++;
         if (dat_oe) break;
      end
      chk(req, k, g + 1);
   endtask

   task automatic card_token(input logic [2:0] st3, input logic endb);
      while (!dat_oe) @(negedge clk);
      while (dat_oe) @(negedge clk);
      @(negedge clk);
      dat_in = 0; @(negedge clk);
      for (int b = 2; b >= 0; b--) begin dat_in = st3[b]; @(negedge clk); end
      dat_in = endb; @(negedge clk);
   endtask

   task automatic card_busy(input int n);
      dat_in = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R7 busy during hold", int'(busy), 1);
      end
      dat_in = 1;
      @(negedge clk);
      chk("R7 busy released", int'(busy), 0);
   endtask

   task automatic ack(input logic [1:0] a);
      flag_ack = a; @(negedge clk); flag_ack = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 dat_oe", int'(dat_oe), 0);
      chk("R1 dat_out", int'(dat_out), 1);
      chk("R1 xfer_en", int'(xfer_en), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 flags", int'({eob_flag, eof_flag, tok_fmt_ok, crc_err, busy}), 0);
      rst_n = 1;
      @(negedge clk);

      // Single block, gap code 0
      mode = 2'd1; gap_code = 2'd0;
      pulse_arm();
      chk("R1 arm sets xfer_en", int'(xfer_en), 1);
      push_words(BLK, 1);
      expect_frame(BLK, 1);
      start_and_time("R3 gap code0", 3);
      card_token(3'b010, 1'b1);
      card_busy(3);
      chk("R8 eob", int'(eob_flag), 1);
      chk("R8 eof", int'(eof_flag), 1);
      chk("R8 xfer_en cleared", int'(xfer_en), 0);
      chk("R5 fmt ok", int'(tok_fmt_ok), 1);
      chk("R5 crc accepted", int'(crc_err), 0);
      chk("R4 frame consumed", exp_q.size(), 0);
      chk("R11 irq set", int'(irq), 1);
      ack(2'b11);
      chk("R11 ack clears", int'({eob_flag, eof_flag, irq}), 0);
      rsp_seen = 0; rsp_ok = 0;
      @(negedge clk);

      // R2 gating: FIFO below half, then card busy, then immediate start
      gap_code = 2'd3;
      pulse_arm();
      push_words(BLK - 1, 2);
      rsp_ok = 1; rsp_seen = 1;
      repeat (15) @(negedge clk);
      chk("R2 fifo below half holds", int'(dat_oe), 0);
      dat_in = 0;
      push_words(1, 3);
      repeat (5) @(negedge clk);
      chk("R2 card busy holds", int'(dat_oe), 0);
      expect_frame(BLK, 1);
      dat_in = 1;
      @(negedge clk);
      chk("R3 aged response starts next edge", int'(dat_oe), 1);
      card_token(3'b101, 1'b0);
      card_busy(2);
      chk("R5 bad end bit", int'(tok_fmt_ok), 0);
      chk("R5 rejected status", int'(crc_err), 1);
      ack(2'b11);
      chk("R6 ack leaves crc_err", int'(crc_err), 1);
      chk("R11 irq from crc_err", int'(irq), 1);
      irq_mask = 3'b011;
      @(negedge clk);
      chk("R11 masked irq", int'(irq), 0);
      crc_clr = 1; @(negedge clk); crc_clr = 0;
      chk("R6 crc_clr clears", int'(crc_err), 0);
      irq_mask = 3'b111;
      rsp_seen = 0; rsp_ok = 0;
      @(negedge clk);

      // R2 bad response, then R3 code 3
      pulse_arm();
      push_words(BLK, 4);
      rsp_seen = 1; rsp_ok = 0;
      repeat (20) @(negedge clk);
      chk("R2 bad response holds", int'(dat_oe), 0);
      rsp_seen = 0; @(negedge clk);
      expect_frame(BLK, 1);
      start_and_time("R3 gap code3", 9);
      card_token(3'b010, 1'b1);
      card_busy(1);
      chk("R8 single end", int'({eob_flag, eof_flag, xfer_en}), 6);
      ack(2'b11);
      rsp_seen = 0; rsp_ok = 0;
      @(negedge clk);

      // Multi block
      mode = 2'd2; gap_code = 2'd1;
      pulse_arm();
      push_words(2 * BLK, 5);
      expect_frame(BLK, 1);
      expect_frame(BLK, 1);
      start_and_time("R3 gap code1", 5);
      card_token(3'b010, 1'b1);
      card_busy(2);
      chk("R9 eob after block", int'(eob_flag), 1);
      chk("R9 no eof without stop", int'(eof_flag), 0);
      chk("R9 still enabled", int'(xfer_en), 1);
      ack(2'b01);
      stop_sent = 1; @(negedge clk); stop_sent = 0;
      card_token(3'b010, 1'b1);
      card_busy(2);
      chk("R9 eof after stop", int'({eob_flag, eof_flag, xfer_en}), 6);
      chk("R9 both blocks sent", exp_q.size(), 0);
      ack(2'b11);
      rsp_seen = 0; rsp_ok = 0;
      @(negedge clk);

      // Stream
      mode = 2'd0; gap_code = 2'd0;
      pulse_arm();
      push_words(6, 6);
      expect_frame(2, 0);
      obs = 0;
      start_and_time("R3 stream start", 3);
      while (obs < 1 + DW + 4) @(negedge clk);
      stop_sent = 1; @(negedge clk); stop_sent = 0;
      while (dat_oe) @(negedge clk);
      chk("R10 eof", int'(eof_flag), 1);
      chk("R10 no eob", int'(eob_flag), 0);
      chk("R10 xfer_en cleared", int'(xfer_en), 0);
      chk("R10 frame consumed", exp_q.size(), 0);
      repeat (2) @(negedge clk);
      chk("R10 no further pops", int'(fifo_level), 4);
      ack(2'b11);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule